// File: doc/BRIEF.md
# Multiframe Reference Generator and Link Latency Meter

This block supports deterministic-latency operation of a receive link. It runs entirely on the link clock and does three jobs. First, it emits a periodic one-cycle reference pulse. The pulse repeats once per multiframe, and the multiframe length is derived from the configured octets per frame and frames per multiframe. Second, it keeps a local multiframe phase counter. A rising edge on the external reference input realigns this counter to a programmable offset.

Alignment has two modes. By default the counter is aligned once: only the first captured edge is used, and an arm indicator drops when that edge arrives. In continuous mode every edge realigns the counter. A one-cycle flag then reports any edge that lands away from the phase the counter would have reached by itself.

Third, the block measures link latency. It counts link clocks from the release of the active-low synchronisation request to the first sampled assertion of receive-valid. The result saturates, and it is held with a done flag until the request is asserted again. Both asynchronous inputs pass through a two-flop synchroniser before their edges are detected.

Top module: `sysref_lat_unit`

## Requirements
- R1: The multiframe length in link clocks is (octets per frame × frames per multiframe) / 4; configurations must make this at least 2.
- R2: While `sysref_gen_en` is high, `sysref_out` is a one-cycle pulse repeating every multiframe length, and the first pulse appears at the first clock edge after enable. While the enable is low, the output stays low.
- R3: If a rising edge of `sysref_in` is first sampled at clock edge n, `lmfc_count` equals `cfg_lmfc_offset` after edge n+2. An offset at or above the multiframe length loads 0.
- R4: Between realignments, `lmfc_count` advances by one per clock and wraps from length−1 to 0. `lmfc_boundary` is high exactly when the count is 0.
- R5: In single mode (`cfg_continuous`=0), `single_arm` is 1 after reset and drops to 0 on the first captured edge. Every later edge leaves the counter and `sysref_misaligned` untouched. `single_arm` never rises except through reset.
- R6: In continuous mode, every edge realigns the counter. `sysref_misaligned` pulses for one cycle, together with the realignment, when the counter would not have reached the offset on its own. It stays 0 on the first alignment after reset and on edges that land on the expected phase.
- R7: If the release (`sync_n_in` going high) is first sampled at edge n, and `rx_valid` is first sampled high at edge v with v ≥ n+3, then after edge v `lat_done`=1 and `lat_count`=v−n. A valid seen earlier than that gives the result 3.
- R8: The result and `lat_done` hold while the request stays released. A low on `sync_n_in` first sampled at edge m clears both after edge m+2.
- R9: The latency count saturates at 2^LAT_W−1 without setting `lat_done`.
- R10: Reset (synchronous, active high) gives `single_arm`=1, `sysref_out`=0, `lmfc_count`=0, `lat_count`=0 and `lat_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_octets_per_frame | input | F_W (5) | Octets per frame |
| cfg_frames_per_mf | input | K_W (6) | Frames per multiframe |
| cfg_lmfc_offset | input | MF_W (9) | Counter value loaded on alignment |
| cfg_continuous | input | 1 | 1: every edge realigns; 0: first edge only |
| sysref_gen_en | input | 1 | Enables the pulse generator |
| sysref_in | input | 1 | Asynchronous reference input |
| sync_n_in | input | 1 | Asynchronous active-low synchronisation request |
| rx_valid | input | 1 | Receive valid, link clock domain |
| sysref_out | output | 1 | Generated reference pulse |
| lmfc_count | output | MF_W (9) | Local multiframe phase |
| lmfc_boundary | output | 1 | High when the phase is 0 |
| single_arm | output | 1 | Single-detection arm state |
| sysref_misaligned | output | 1 | One-cycle off-phase edge flag |
| lat_count | output | LAT_W (10) | Measured or running latency |
| lat_done | output | 1 | Latency result valid |

## Verification
Each result has a fixed due time. A generated pulse is due at the edge right after enable and then once per multiframe length. An input edge moves the counter two edges after its first sample. A latency result is due on the edge that first samples valid. A request reassertion clears the result two edges after its first sample. The bench drives inputs and samples outputs only on falling edges, and it counts those falling edges from the drive point, so every check lands in the cycle named in the requirement. It also checks one cycle earlier where a premature change would be an error.

// File: rtl/sysref_lat_pkg.sv
package sysref_lat_pkg;
  // flops in each input synchroniser
  localparam int unsigned SYNC_STAGES = 2;
  // latency reported when valid is seen on the first possible edge
  localparam int unsigned LAT_START = SYNC_STAGES + 1;

  typedef enum logic [1:0] {
    MEAS_IDLE,
    MEAS_RUN,
    MEAS_HELD
  } meas_state_e;
endpackage

// File: rtl/slu_sync.sv
module slu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/slu_sysref_gen.sv
module slu_sysref_gen #(
  parameter int unsigned MF_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MF_W-1:0] mf_len,
  output logic            pulse
);
  logic [MF_W-1:0] phase;
  logic [MF_W-1:0] last;

  always_comb last = mf_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (phase == '0);
      phase <= (phase >= last) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/slu_lmfc.sv
module slu_lmfc #(
  parameter int unsigned MF_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MF_W-1:0] mf_len,
  input  logic [MF_W-1:0] offset,
  input  logic            continuous,
  input  logic            ref_lvl,
  output logic [MF_W-1:0] count,
  output logic            boundary,
  output logic            armed,
  output logic            misaligned
);
  logic            ref_prev;
  logic            ref_rise;
  logic            take;
  logic            aligned;
  logic [MF_W-1:0] last;
  logic [MF_W-1:0] nxt;
  logic [MF_W-1:0] load_val;

  always_comb begin
    last     = mf_len - 1'b1;
    nxt      = (count >= last) ? '0 : count + 1'b1;
    load_val = (offset > last) ? '0 : offset;
    ref_rise = ref_lvl & ~ref_prev;
    take     = ref_rise & (armed | continuous);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev   <= 1'b0;
      count      <= '0;
      boundary   <= 1'b1;
      armed      <= 1'b1;
      aligned    <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      ref_prev   <= ref_lvl;
      misaligned <= take & aligned & (nxt != load_val);
      if (ref_rise) armed <= 1'b0;
      if (take) begin
        count    <= load_val;
        boundary <= (load_val == '0);
        aligned  <= 1'b1;
      end else begin
        count    <= nxt;
        boundary <= (nxt == '0);
      end
    end
  end
endmodule

// File: rtl/slu_lat_meter.sv
module slu_lat_meter
  import sysref_lat_pkg::*;
#(
  parameter int unsigned LAT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             released,
  input  logic             valid,
  output logic [LAT_W-1:0] count,
  output logic             done
);
  localparam logic [LAT_W-1:0] CNT_MAX = '1;
  localparam logic [LAT_W-1:0] CNT_START = LAT_W'(LAT_START);

  meas_state_e state;
  logic        rel_prev;
  logic        rel_rise;

  always_comb rel_rise = released & ~rel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MEAS_IDLE;
      rel_prev <= 1'b0;
      count    <= '0;
      done     <= 1'b0;
    end else begin
      rel_prev <= released;
      if (!released) begin
        state <= MEAS_IDLE;
        count <= '0;
        done  <= 1'b0;
      end else if (rel_rise) begin
        state <= MEAS_RUN;
        count <= CNT_START;
        done  <= 1'b0;
      end else begin
        case (state)
          MEAS_RUN: begin
            if (valid) begin
              state <= MEAS_HELD;
              done  <= 1'b1;
            end else if (count != CNT_MAX) begin
              count <= count + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysref_lat_unit.sv
module sysref_lat_unit
  import sysref_lat_pkg::*;
#(
  parameter int unsigned F_W   = 5,
  parameter int unsigned K_W   = 6,
  parameter int unsigned LAT_W = 10,
  parameter int unsigned MF_W  = F_W + K_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [F_W-1:0]   cfg_octets_per_frame,
  input  logic [K_W-1:0]   cfg_frames_per_mf,
  input  logic [MF_W-1:0]  cfg_lmfc_offset,
  input  logic             cfg_continuous,
  input  logic             sysref_gen_en,
  input  logic             sysref_in,
  input  logic             sync_n_in,
  input  logic             rx_valid,
  output logic             sysref_out,
  output logic [MF_W-1:0]  lmfc_count,
  output logic             lmfc_boundary,
  output logic             single_arm,
  output logic             sysref_misaligned,
  output logic [LAT_W-1:0] lat_count,
  output logic             lat_done
);
  localparam int unsigned PROD_W = F_W + K_W;

  logic [PROD_W-1:0] octets_per_mf;
  logic [MF_W-1:0]   mf_len_q;
  logic [1:0]        async_in;
  logic [1:0]        synced;

  // 32-bit datapath: four octets per link clock
  always_comb octets_per_mf = {{K_W{1'b0}}, cfg_octets_per_frame}
                            * {{F_W{1'b0}}, cfg_frames_per_mf};

  always_ff @(posedge clk) mf_len_q <= octets_per_mf[PROD_W-1:2];

  assign async_in = {sync_n_in, sysref_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    slu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (async_in[g]),
      .dout (synced[g])
    );
  end

  slu_sysref_gen #(.MF_W(MF_W)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .en     (sysref_gen_en),
    .mf_len (mf_len_q),
    .pulse  (sysref_out)
  );

  slu_lmfc #(.MF_W(MF_W)) u_lmfc (
    .clk        (clk),
    .rst        (rst),
    .mf_len     (mf_len_q),
    .offset     (cfg_lmfc_offset),
    .continuous (cfg_continuous),
    .ref_lvl    (synced[0]),
    .count      (lmfc_count),
    .boundary   (lmfc_boundary),
    .armed      (single_arm),
    .misaligned (sysref_misaligned)
  );

  slu_lat_meter #(.LAT_W(LAT_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .released (synced[1]),
    .valid    (rx_valid),
    .count    (lat_count),
    .done     (lat_done)
  );
endmodule

// File: rtl/slu_checker.sv
module slu_checker
  import sysref_lat_pkg::*;
#(
  parameter int unsigned F_W   = 5,
  parameter int unsigned K_W   = 6,
  parameter int unsigned LAT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [F_W-1:0]   cfg_octets_per_frame,
  input logic [K_W-1:0]   cfg_frames_per_mf,
  input logic             cfg_continuous,
  input logic             sysref_gen_en,
  input logic             sysref_out,
  input logic             single_arm,
  input logic             sysref_misaligned,
  input logic [LAT_W-1:0] lat_count,
  input logic             lat_done
);
  localparam logic [LAT_W-1:0] SAT = '1;
  logic [F_W+K_W-1:0] prod;
  assign prod = {{K_W{1'b0}}, cfg_octets_per_frame} * {{F_W{1'b0}}, cfg_frames_per_mf};

  // R2
  sysref_width_chk: assert property (@(posedge clk) disable iff (rst)
    (sysref_out && (prod >= 8) && $stable(prod)) |=> !sysref_out);

  // R2
  sysref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sysref_gen_en |=> !sysref_out);

  // R5
  arm_once_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(single_arm));

  // R6
  misalign_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sysref_misaligned |-> $past(cfg_continuous));

  // R7
  result_floor_chk: assert property (@(posedge clk) disable iff (rst)
    lat_done |-> (lat_count >= LAT_W'(LAT_START)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lat_done |=> (!lat_done || $stable(lat_count)));

  // R9
  result_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_count == SAT) |=> ((lat_count == SAT) || (lat_count == '0)));
endmodule

bind sysref_lat_unit slu_checker #(.F_W(F_W), .K_W(K_W), .LAT_W(LAT_W)) u_chk (
  .clk                  (clk),
  .rst                  (rst),
  .cfg_octets_per_frame (cfg_octets_per_frame),
  .cfg_frames_per_mf    (cfg_frames_per_mf),
  .cfg_continuous       (cfg_continuous),
  .sysref_gen_en        (sysref_gen_en),
  .sysref_out           (sysref_out),
  .single_arm           (single_arm),
  .sysref_misaligned    (sysref_misaligned),
  .lat_count            (lat_count),
  .lat_done             (lat_done)
);

// File: tb/sim_sysref_lat_unit.sv
module sim_sysref_lat_unit;
  localparam int F_W = 5, K_W = 6, LAT_W = 10, MF_W = F_W + K_W - 2;
  localparam int SAT = (1 << LAT_W) - 1;

  typedef struct packed {
    int f;
    int k;
    int off;
    int d;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2, 16, 0, 5},
    '{1, 32, 3, 20},
    '{4, 32, 5, 75},
    '{1, 16, 1, 3},
    '{8, 16, 10, 115},
    '{2, 20, 7, 53}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [F_W-1:0]   cfg_f = 5'd2;
  logic [K_W-1:0]   cfg_k = 6'd16;
  logic [MF_W-1:0]  cfg_off = '0;
  logic             cfg_cont = 1'b0;
  logic             gen_en = 1'b0;
  logic             loop_en = 1'b0;
  logic             sysref_drv = 1'b0;
  logic             sync_n = 1'b0;
  logic             valid = 1'b0;
  logic             sysref_in;
  logic             sysref_out;
  logic [MF_W-1:0]  lmfc_count;
  logic             lmfc_boundary;
  logic             single_arm;
  logic             misaligned;
  logic [LAT_W-1:0] lat_count;
  logic             lat_done;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign sysref_in = loop_en ? sysref_out : sysref_drv;

  sysref_lat_unit u0 (
    .clk                  (clk),
    .rst                  (rst),
    .cfg_octets_per_frame (cfg_f),
    .cfg_frames_per_mf    (cfg_k),
    .cfg_lmfc_offset      (cfg_off),
    .cfg_continuous       (cfg_cont),
    .sysref_gen_en        (gen_en),
    .sysref_in            (sysref_in),
    .sync_n_in            (sync_n),
    .rx_valid             (valid),
    .sysref_out           (sysref_out),
    .lmfc_count           (lmfc_count),
    .lmfc_boundary        (lmfc_boundary),
    .single_arm           (single_arm),
    .sysref_misaligned    (misaligned),
    .lat_count            (lat_count),
    .lat_done             (lat_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 arm", int'(single_arm), 1);
    chk("R10 sysref_out", int'(sysref_out), 0);
    chk("R10 lmfc_count", int'(lmfc_count), 0);
    chk("R10 lat_count", int'(lat_count), 0);
    chk("R10 lat_done", int'(lat_done), 0);
    rst = 1'b0;
  endtask

  task automatic pulse_in();
    sysref_drv = 1'b1;
    @(negedge clk);
    sysref_drv = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int len;
    int guard;
    len = (v.f * v.k) / 4;
    cfg_f = F_W'(v.f); cfg_k = K_W'(v.k); cfg_off = MF_W'(v.off);
    cfg_cont = 1'b0; loop_en = 1'b1; gen_en = 1'b0; sync_n = 1'b0; valid = 1'b0;
    do_reset();
    gen_en = 1'b1;
    @(negedge clk);
    chk("R2 first pulse", int'(sysref_out), 1);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (i == 1) chk("R2 width", int'(sysref_out), 0);
      if (i == 3) chk("R3 load offset", int'(lmfc_count), v.off);
    end
    // R1 period equals F*K/4
    chk("R1 R2 period", int'(sysref_out), 1);
    chk("R4 count", int'(lmfc_count), (v.off + len - 3) % len);
    chk("R4 boundary", int'(lmfc_boundary), ((v.off + len - 3) % len) == 0 ? 1 : 0);
    chk("R5 arm cleared", int'(single_arm), 0);
    // latency measurement
    sync_n = 1'b1;
    repeat (v.d) @(negedge clk);
    chk("R7 not done early", int'(lat_done), 0);
    valid = 1'b1;
    @(negedge clk);
    chk("R7 done", int'(lat_done), 1);
    chk("R7 count", int'(lat_count), v.d);
    valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 hold", int'(lat_count), v.d);
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 still held", int'(lat_done), 1);
    @(negedge clk);
    chk("R8 cleared done", int'(lat_done), 0);
    chk("R8 cleared count", int'(lat_count), 0);
    guard = 0;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    foreach (VECS[i]) run_vec(VECS[i]);

    // R9 saturation with no valid
    loop_en = 1'b0; gen_en = 1'b0; cfg_f = 5'd2; cfg_k = 6'd16; cfg_off = '0;
    do_reset();
    sync_n = 1'b1;
    repeat (1100) @(negedge clk);
    chk("R9 saturated", int'(lat_count), SAT);
    chk("R9 no done", int'(lat_done), 0);
    valid = 1'b1;
    @(negedge clk);
    chk("R9 done at sat", int'(lat_done), 1);
    chk("R9 count at sat", int'(lat_count), SAT);
    valid = 1'b0; sync_n = 1'b0;
    chk("R2 disabled low", int'(sysref_out), 0);

    // R7 valid already high at release
    do_reset();
    sync_n = 1'b1; valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 early valid wait", int'(lat_done), 0);
    @(negedge clk);
    chk("R7 early valid done", int'(lat_done), 1);
    chk("R7 early valid count", int'(lat_count), 3);
    valid = 1'b0; sync_n = 1'b0;

    // R5 single mode ignores later edges (length 8, offset 0)
    cfg_cont = 1'b0;
    do_reset();
    pulse_in();
    repeat (2) @(negedge clk);
    chk("R3 manual load", int'(lmfc_count), 0);
    chk("R5 arm dropped", int'(single_arm), 0);
    repeat (2) @(negedge clk);
    pulse_in();
    repeat (2) @(negedge clk);
    chk("R5 later edge ignored", int'(lmfc_count), 5);
    chk("R5 no flag", int'(misaligned), 0);

    // R6 continuous realignment
    cfg_cont = 1'b1;
    do_reset();
    pulse_in();
    repeat (2) @(negedge clk);
    chk("R6 first align", int'(lmfc_count), 0);
    chk("R6 first no flag", int'(misaligned), 0);
    repeat (2) @(negedge clk);
    pulse_in();
    repeat (2) @(negedge clk);
    chk("R6 realigned", int'(lmfc_count), 0);
    chk("R6 flag", int'(misaligned), 1);
    @(negedge clk);
    chk("R6 flag one cycle", int'(misaligned), 0);
    chk("R4 advance", int'(lmfc_count), 1);
    repeat (4) @(negedge clk);
    pulse_in();
    repeat (2) @(negedge clk);
    chk("R6 on-phase count", int'(lmfc_count), 0);
    chk("R6 on-phase no flag", int'(misaligned), 0);
    chk("R4 boundary at zero", int'(lmfc_boundary), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule